// File: doc/BRIEF.md
# Master Byte Transfer Sequencer

This block runs the master side of a two-wire serial transfer one byte at a time. It does not make the bus waveform. It sends a bus-master engine one operation per handshake: a start with the slave address, a byte write, a byte read, or a stop. The engine returns the acknowledge bit and the read data in the same handshake. Control software supplies these settings as plain levels:
- enable, master, direction and repeat mode;
- a byte count;
- a slave address;
- one-cycle start and stop pulses.

Bytes to send arrive on a valid/ready stream. Received bytes leave through a small queue on a second valid/ready stream.

Streams follow the usual rules. A byte moves only in a cycle where valid and ready are both high. The sequencer raises `tx_ready` only in the cycle it writes the offered byte to the bus. A receive byte stays on `rx_data` until the consumer takes it. When the receive queue is full, the sequencer stops issuing reads and continues once space frees up.

In normal mode the byte count limits the transfer. When the count runs out, the sequencer either closes the bus with a stop, if one was requested, or parks the bus and raises access-ready. In repeat mode the count is ignored. Data moves until an explicit stop request.

Top module: `byte_xfer_seq`

## Requirements
- R1: After reset, and in any cycle following one with `en` low, the block is idle. `bus_busy`, `mst_active`, `acc_ready`, `nack_flag`, `stop_pending`, `bus_cmd_valid`, `tx_ready` and `rx_valid` are all 0, and `cur_count` is 0.
- R2: A `start` pulse while `en` and `master` are high, with the block idle or parked, issues op 0 (start). Its data is the 7-bit address in bits 7:1 and a read flag in bit 0, equal to the inverse of `tx_dir`. A `start` pulse with `master` low does nothing.
- R3: If the slave does not acknowledge the address, `nack_flag` goes to 1, any pending stop is dropped, and the bus is released. If it does, `cur_count` is loaded from `byte_count`.
- R4: In normal transmit, op 1 (write) is issued with the offered byte only while `cur_count` is nonzero. Each write consumes exactly one stream byte and decrements `cur_count` by one.
- R5: In normal mode with no stop pending, a count of zero raises `acc_ready`, clears `mst_active`, and keeps the bus busy. No further data ops are issued until a stop request, which then issues op 3.
- R6: In normal mode with a stop pending, a count of zero issues op 3 (stop). `stop_pending` is then cleared, `cur_count` is reloaded from `byte_count`, and the bus is released.
- R7: In normal receive, op 2 (read) is issued while `cur_count` is nonzero and the queue (depth 4) has room. Received bytes leave in bus order.
- R8: In repeat mode `cur_count` never changes. Transmit writes every offered byte while `xfer_ready` stays 1. Receive reads until the queue holds 4 bytes, then stalls.
- R9: In repeat mode a pending stop is issued ahead of any further data op.
- R10: A write that the slave does not acknowledge ends sending. `nack_flag` is set, `stop_pending` is cleared, `xfer_ready` drops, and remaining stream bytes are left unconsumed.
- R11: `tx_ready` is never high without `tx_valid`. A stalled `rx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Block enable; low clears all state |
| master | input | 1 | Master mode select; start needs it high |
| tx_dir | input | 1 | 1 = transmit, 0 = receive |
| start | input | 1 | Start request pulse |
| stop | input | 1 | Stop request pulse |
| repeat_mode | input | 1 | Ignore count, run until stop |
| byte_count | input | CNT_W | Programmed byte count |
| slave_addr | input | 7 | Target slave address |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte taken |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes received byte |
| rx_data | output | 8 | Received byte |
| bus_cmd_valid | output | 1 | Operation request to bus engine |
| bus_cmd_ready | input | 1 | Bus engine completes the operation |
| bus_cmd_op | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| bus_cmd_data | output | 8 | Address byte or write byte |
| bus_ack | input | 1 | Slave acknowledge, valid with the handshake |
| bus_rdata | input | 8 | Read byte, valid with the handshake |
| bus_busy | output | 1 | Transfer holds the bus |
| mst_active | output | 1 | Master bit, cleared when the count is done |
| xfer_ready | output | 1 | Transmit wants more bytes |
| acc_ready | output | 1 | Access-ready flag |
| nack_flag | output | 1 | No-acknowledge seen |
| stop_pending | output | 1 | Stop requested, not yet issued |
| cur_count | output | CNT_W | Remaining byte count |

## Verification
Some properties are checked on every cycle:
- a pending stop is dropped after a refused write;
- nothing is pushed into a full queue;
- a stalled receive byte holds its value;
- repeat mode leaves the count untouched;
- no data op is issued with a zero count in normal mode;
- a start op only appears while the master bit is set.

Other behaviour shows only in the bench scenarios:
- the exact order of bus operations and address bytes;
- where the count runs out, with or without a stop;
- the stop taking priority in repeat mode;
- the address refusal;
- the stall against a full queue.

The scoreboard compares each of these against the expected operation and byte sequences.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RUN,
    ST_HOLD
  } seq_st_e;
endpackage

// File: rtl/bxs_rxq.sv
module bxs_rxq #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] fill;
  logic          pop;

  assign pop       = out_valid & out_ready;
  assign out_valid = (fill != '0);
  assign full      = (fill == LW'(DEPTH));
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   fill <= fill + LW'(1);
        2'b01:   fill <= fill - LW'(1);
        default: fill <= fill;
      endcase
    end
  end

  // R7: no write into a full queue
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R11: a stalled output byte stays put
  assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/bxs_ctrl.sv
module bxs_ctrl
  import bxs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              master,
  input  logic              tx_dir,
  input  logic              start,
  input  logic              stop,
  input  logic              repeat_mode,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_full,
  output logic              rx_push,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output bus_op_e           cmd_op,
  output logic [BYTE_W-1:0] cmd_data,
  input  logic              bus_ack,
  output logic              busy,
  output logic              mst,
  output logic              xfer_rdy,
  output logic              ardy,
  output logic              nack,
  output logic              stop_pend,
  output logic [CNT_W-1:0]  cnt
);
  seq_st_e st;
  logic    dir_q;
  logic    hs, cnt_live, want_stop;

  assign hs        = cmd_valid & cmd_ready;
  assign cnt_live  = repeat_mode | (cnt != '0);
  assign want_stop = stop_pend & (repeat_mode | (cnt == '0));

  always_comb begin
    cmd_valid = 1'b0;
    cmd_op    = OP_START;
    cmd_data  = '0;
    case (st)
      ST_ADDR: begin
        cmd_valid = 1'b1;
        cmd_data  = {slave_addr, ~dir_q};
      end
      ST_RUN: begin
        if (want_stop) begin
          cmd_valid = 1'b1;
          cmd_op    = OP_STOP;
        end else if (cnt_live) begin
          if (dir_q) begin
            cmd_valid = tx_valid;
            cmd_op    = OP_WRITE;
            cmd_data  = tx_data;
          end else begin
            cmd_valid = !rx_full;
            cmd_op    = OP_READ;
          end
        end
      end
      ST_HOLD: begin
        if (stop_pend) begin
          cmd_valid = 1'b1;
          cmd_op    = OP_STOP;
        end
      end
      default: ;
    endcase
  end

  assign tx_ready = hs && (cmd_op == OP_WRITE);
  assign rx_push  = hs && (cmd_op == OP_READ);
  assign xfer_rdy = (st == ST_RUN) && dir_q && cnt_live && !stop_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; dir_q <= 1'b0; busy <= 1'b0; mst <= 1'b0;
      ardy <= 1'b0; nack <= 1'b0; stop_pend <= 1'b0; cnt <= '0;
    end else if (!en) begin
      st <= ST_IDLE; dir_q <= 1'b0; busy <= 1'b0; mst <= 1'b0;
      ardy <= 1'b0; nack <= 1'b0; stop_pend <= 1'b0; cnt <= '0;
    end else begin
      if (stop) stop_pend <= 1'b1;
      case (st)
        ST_ADDR: begin
          if (hs) begin
            if (!bus_ack) begin
              nack      <= 1'b1;
              stop_pend <= 1'b0;
              busy      <= 1'b0;
              mst       <= 1'b0;
              st        <= ST_IDLE;
            end else begin
              cnt <= byte_count;
              st  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (hs) begin
            case (cmd_op)
              OP_STOP: begin
                stop_pend <= 1'b0;
                cnt       <= byte_count;
                busy      <= 1'b0;
                mst       <= 1'b0;
                st        <= ST_IDLE;
              end
              OP_WRITE: begin
                if (!repeat_mode) cnt <= cnt - CNT_W'(1);
                if (!bus_ack) begin
                  nack      <= 1'b1;
                  stop_pend <= 1'b0;
                  st        <= ST_HOLD;
                end
              end
              default: if (!repeat_mode) cnt <= cnt - CNT_W'(1);
            endcase
          end else if (!repeat_mode && cnt == '0 && !stop_pend) begin
            ardy <= 1'b1;
            mst  <= 1'b0;
            st   <= ST_HOLD;
          end
        end
        default: begin
          if (hs) begin
            stop_pend <= 1'b0;
            cnt       <= byte_count;
            busy      <= 1'b0;
            mst       <= 1'b0;
            st        <= ST_IDLE;
          end else if (start && master) begin
            st    <= ST_ADDR;
            busy  <= 1'b1;
            mst   <= 1'b1;
            dir_q <= tx_dir;
            nack  <= 1'b0;
            ardy  <= 1'b0;
          end
        end
      endcase
    end
  end

  // R10: a refused write always leaves no stop pending and the flag set
  assert_nack_drops_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && en && cmd_op == OP_WRITE && !bus_ack) |=> (!stop_pend && nack));

  // R8: repeat mode data ops leave the count untouched
  assert_repeat_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && en && repeat_mode && (cmd_op == OP_WRITE || cmd_op == OP_READ))
      |=> (cnt == $past(cnt)));

  // R4: normal mode never moves data with an empty count
  assert_no_zero_count_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !repeat_mode && (cmd_op == OP_WRITE || cmd_op == OP_READ))
      |-> (cnt != '0));

  // R11: the transmit stream is taken only when offered
  assert_tx_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_valid);

  // R2: a start op appears only with the master bit set
  assert_start_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_START) |-> (mst && busy));
endmodule

// File: rtl/byte_xfer_seq.sv
module byte_xfer_seq #(
  parameter int CNT_W     = 16,
  parameter int RXQ_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             master,
  input  logic             tx_dir,
  input  logic             start,
  input  logic             stop,
  input  logic             repeat_mode,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [6:0]       slave_addr,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             bus_cmd_valid,
  input  logic             bus_cmd_ready,
  output logic [1:0]       bus_cmd_op,
  output logic [7:0]       bus_cmd_data,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata,
  output logic             bus_busy,
  output logic             mst_active,
  output logic             xfer_ready,
  output logic             acc_ready,
  output logic             nack_flag,
  output logic             stop_pending,
  output logic [CNT_W-1:0] cur_count
);
  import bxs_pkg::*;

  logic    rx_full, rx_push;
  bus_op_e op;

  assign bus_cmd_op = op;

  bxs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .tx_dir(tx_dir),
    .start(start), .stop(stop), .repeat_mode(repeat_mode),
    .byte_count(byte_count), .slave_addr(slave_addr),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_full(rx_full), .rx_push(rx_push),
    .cmd_valid(bus_cmd_valid), .cmd_ready(bus_cmd_ready), .cmd_op(op),
    .cmd_data(bus_cmd_data), .bus_ack(bus_ack),
    .busy(bus_busy), .mst(mst_active), .xfer_rdy(xfer_ready),
    .ardy(acc_ready), .nack(nack_flag), .stop_pend(stop_pending),
    .cnt(cur_count)
  );

  bxs_rxq #(.W(BYTE_W), .DEPTH(RXQ_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(!en),
    .push(rx_push), .push_data(bus_rdata), .full(rx_full),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_data)
  );
endmodule

// File: tb/tb_byte_xfer_seq.sv
module tb_byte_xfer_seq;
  logic clk = 0, rst_n = 0, en = 0, master = 1, tx_dir = 1;
  logic start = 0, stop = 0, repeat_mode = 0;
  logic [15:0] byte_count = 0;
  logic [6:0]  slave_addr = 7'h2A;
  logic tx_valid = 0, tx_ready, rx_valid, rx_ready = 1;
  logic [7:0] tx_data = 0, rx_data;
  logic bus_cmd_valid, bus_cmd_ready = 0, bus_ack;
  logic [1:0] bus_cmd_op;
  logic [7:0] bus_cmd_data, bus_rdata;
  logic bus_busy, mst_active, xfer_ready, acc_ready, nack_flag, stop_pending;
  logic [15:0] cur_count;

  int total = 0, bad = 0, wr_idx = 0, nack_at = -1, rdy_ctr = 0;
  logic nack_addr = 0, hold_bus = 0, done = 0;
  logic [7:0] rd_val = 8'hA0;
  logic [7:0] txq [$];
  logic [9:0] exp_q [$];
  logic [7:0] exp_rx [$];

  always #10 clk = ~clk;

  assign bus_ack = (bus_cmd_op == 2'd0) ? !nack_addr :
                   (bus_cmd_op == 2'd1) ? (wr_idx != nack_at) : 1'b1;
  assign bus_rdata = rd_val;

  byte_xfer_seq dut (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: evaluates the handshake that completes at the next edge
  always begin
    logic hs, txp, rxp;
    logic [1:0] op;
    @(negedge clk);
    rdy_ctr++;
    bus_cmd_ready = !hold_bus && (rdy_ctr % 3 != 1);
    #1;
    hs = bus_cmd_valid && bus_cmd_ready;
    op = bus_cmd_op;
    txp = tx_valid && tx_ready;
    rxp = rx_valid && rx_ready;
    if (hs) begin
      logic [9:0] got;
      got = {op, (op == 2'd0 || op == 2'd1) ? bus_cmd_data : 8'h00};
      if (exp_q.size() == 0) chk(0, "R2 unexpected bus op", got, 0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R2/R4/R6 bus op", got, e);
      end
    end
    if (rxp) begin
      if (exp_rx.size() == 0) chk(0, "R7 unexpected rx byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        chk(rx_data == e, "R7 rx byte order", rx_data, e);
      end
    end
    @(posedge clk); #1;
    if (hs && op == 2'd1) wr_idx++;
    if (hs && op == 2'd2) rd_val++;
    if (txp) begin
      void'(txq.pop_front());
      tx_valid = (txq.size() != 0);
      tx_data  = (txq.size() != 0) ? txq[0] : 8'h00;
    end
  end

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_start; @(negedge clk); start = 1; @(negedge clk); start = 0; endtask
  task automatic pulse_stop;  @(negedge clk); stop = 1;  @(negedge clk); stop = 0;  endtask
  task automatic push_tx(input logic [7:0] b, input logic expect_it);
    txq.push_back(b);
    tx_valid = 1; tx_data = txq[0];
    if (expect_it) exp_q.push_back({2'd1, b});
  endtask
  task automatic flush_tx; txq.delete(); tx_valid = 0; tx_data = 0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; en = 1; idle(2);
    // R1 reset state
    chk(!bus_busy && !bus_cmd_valid && !tx_ready && !rx_valid, "R1 idle outputs", bus_busy, 0);
    chk(!nack_flag && !acc_ready && !stop_pending && !mst_active, "R1 flags", {nack_flag,acc_ready}, 0);
    chk(cur_count == 0, "R1 count", cur_count, 0);

    // T2: normal transmit of 3 with stop (R2 R4 R6)
    byte_count = 3; tx_dir = 1;
    pulse_stop;
    exp_q.push_back({2'd0, 8'h54});
    push_tx(8'h11, 1); push_tx(8'h22, 1); push_tx(8'h33, 1);
    exp_q.push_back({2'd3, 8'h00});
    pulse_start; idle(40);
    chk(exp_q.size() == 0, "R4 all ops seen", exp_q.size(), 0);
    chk(!bus_busy && !stop_pending, "R6 released", bus_busy, 0);
    chk(cur_count == 3, "R6 count reload", cur_count, 3);

    // T3: count runs out without stop (R5)
    byte_count = 2;
    exp_q.push_back({2'd0, 8'h54});
    push_tx(8'h44, 1); push_tx(8'h55, 1); push_tx(8'h66, 0);
    pulse_start; idle(30);
    chk(acc_ready && !mst_active && bus_busy, "R5 access ready", {acc_ready,mst_active,bus_busy}, 3'b101);
    chk(!xfer_ready, "R5 no more wanted", xfer_ready, 0);
    chk(txq.size() == 1, "R5 extra byte untouched", txq.size(), 1);
    exp_q.push_back({2'd3, 8'h00});
    pulse_stop; idle(20);
    chk(!bus_busy && exp_q.size() == 0, "R5 stop after park", bus_busy, 0);
    flush_tx;

    // T4: normal receive of 5 with stalled consumer (R7 R11)
    tx_dir = 0; byte_count = 5; rx_ready = 0; rd_val = 8'hA0;
    pulse_stop;
    exp_q.push_back({2'd0, 8'h55});
    for (int i = 0; i < 4; i++) exp_q.push_back({2'd2, 8'h00});
    pulse_start; idle(40);
    chk(exp_q.size() == 0, "R7 four reads then stall", exp_q.size(), 0);
    chk(cur_count == 1, "R7 count after stall", cur_count, 1);
    chk(rx_valid && rx_data == 8'hA0, "R11 held rx byte", rx_data, 8'hA0);
    exp_q.push_back({2'd2, 8'h00}); exp_q.push_back({2'd3, 8'h00});
    for (int i = 0; i < 5; i++) exp_rx.push_back(8'hA0 + 8'(i));
    rx_ready = 1; idle(40);
    chk(exp_q.size() == 0 && exp_rx.size() == 0, "R7 drain and stop", exp_rx.size(), 0);
    chk(!bus_busy, "R6 rx released", bus_busy, 0);

    // T5: repeat transmit (R8 R9)
    tx_dir = 1; repeat_mode = 1; byte_count = 7;
    exp_q.push_back({2'd0, 8'h54});
    for (int i = 0; i < 6; i++) push_tx(8'h70 + 8'(i), 1);
    pulse_start; idle(40);
    chk(exp_q.size() == 0, "R8 all bytes sent", exp_q.size(), 0);
    chk(cur_count == 7, "R8 count unchanged", cur_count, 7);
    chk(xfer_ready && bus_busy, "R8 still wants data", xfer_ready, 1);
    @(negedge clk); hold_bus = 1;
    push_tx(8'h99, 0);
    pulse_stop;
    exp_q.push_back({2'd3, 8'h00});
    @(negedge clk); hold_bus = 0; idle(20);
    chk(exp_q.size() == 0 && !bus_busy, "R9 stop first", bus_busy, 0);
    chk(txq.size() == 1, "R9 byte left", txq.size(), 1);
    flush_tx;

    // T6: repeat receive fills queue (R8 R9)
    tx_dir = 0; rx_ready = 0; rd_val = 8'hB0;
    exp_q.push_back({2'd0, 8'h55});
    for (int i = 0; i < 4; i++) exp_q.push_back({2'd2, 8'h00});
    pulse_start; idle(40);
    chk(exp_q.size() == 0 && rx_valid, "R8 rx fills to four", exp_q.size(), 0);
    exp_q.push_back({2'd3, 8'h00});
    pulse_stop; idle(20);
    chk(!bus_busy && exp_q.size() == 0, "R9 rx stop", bus_busy, 0);
    for (int i = 0; i < 4; i++) exp_rx.push_back(8'hB0 + 8'(i));
    rx_ready = 1; idle(20);
    chk(exp_rx.size() == 0, "R8 rx drained", exp_rx.size(), 0);
    repeat_mode = 0;

    // T7: address refused (R3)
    tx_dir = 1; nack_addr = 1; byte_count = 2;
    pulse_stop;
    exp_q.push_back({2'd0, 8'h54});
    pulse_start; idle(20);
    chk(nack_flag && !stop_pending, "R3 nack drops stop", {nack_flag,stop_pending}, 2'b10);
    chk(!bus_busy && !mst_active && exp_q.size() == 0, "R3 bus released", bus_busy, 0);
    nack_addr = 0;

    // T8: refused data byte (R10)
    byte_count = 4; nack_at = wr_idx + 1;
    pulse_stop;
    exp_q.push_back({2'd0, 8'h54});
    push_tx(8'hC1, 1); push_tx(8'hC2, 1); push_tx(8'hC3, 0); push_tx(8'hC4, 0);
    pulse_start; idle(30);
    chk(nack_flag && !stop_pending && !xfer_ready, "R10 flags", {nack_flag,stop_pending,xfer_ready}, 3'b100);
    chk(txq.size() == 2 && exp_q.size() == 0, "R10 bytes kept", txq.size(), 2);
    exp_q.push_back({2'd3, 8'h00});
    pulse_stop; idle(20);
    chk(!bus_busy, "R10 stop after nack", bus_busy, 0);
    flush_tx; nack_at = -1;

    // T9: start ignored without master (R2)
    master = 0; pulse_start; idle(10);
    chk(!bus_busy && !mst_active, "R2 no master no start", bus_busy, 0);
    master = 1;

    // T10: enable low clears (R1)
    byte_count = 1;
    exp_q.push_back({2'd0, 8'h54});
    push_tx(8'hD0, 1);
    pulse_start; idle(20);
    chk(acc_ready && bus_busy, "R5 parked before clear", acc_ready, 1);
    @(negedge clk); en = 0; idle(2);
    chk(!bus_busy && !acc_ready && !mst_active && cur_count == 0, "R1 enable clear", bus_busy, 0);
    en = 1; idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule